// File: doc/BRIEF.md
# Right-Shift and Nibble-Swap Execution Unit

This unit decodes and executes the single-register right-shift group of an 8-bit microcontroller core. Each cycle it may receive one 16-bit instruction word with a valid strobe, together with the current value of the addressed register and the current carry flag. If the word belongs to the group, the unit computes the new register byte and the new arithmetic flags. Four operations are covered: a logical shift right, a rotate right through carry, an arithmetic shift right and an exchange of the two nibbles.

The core's register file and status register merge the results themselves. The unit returns the result byte, the destination register index and a write-enable. It also returns an 8-bit status vector with an 8-bit per-flag update mask. A word outside the group raises a no-match strobe and changes nothing. All results are registered once, one clock after the accepted strobe.

Top module: `shr_swap_unit`

## Requirements
- R1: A word is accepted when bits [15:9] equal 1001010 and bits [3:0] are 0110 (logical shift), 0111 (rotate), 0101 (arithmetic shift) or 0010 (swap). `dst_idx` then returns bits [8:4].
- R2: Logical shift right returns {0, value[7:1]} and sets C to the old value[0].
- R3: Rotate right returns {carry_in, value[7:1]} and sets C to the old value[0].
- R4: Arithmetic shift right returns {value[7], value[7:1]} and sets C to the old value[0].
- R5: Swap returns {value[3:0], value[7:4]} with `wr_en` high and all of `flag_upd` zero.
- R6: For the three shifts, Z (status bit 1) is 1 exactly when the result byte is zero.
- R7: For logical shift right, N (bit 2) is 0, V (bit 3) equals the new C (bit 0), and S (bit 4) equals V.
- R8: For rotate and arithmetic shift, N equals result bit 7, V equals N XOR the new C, and S equals N XOR V.
- R9: The three shifts update exactly bits C, Z, N, V, S (`flag_upd` = 0x1F). Bits 5 to 7 (H, T, I) are never marked for update by any word.
- R10: A valid word outside the group gives `no_match` = 1, `wr_en` = 0 and `flag_upd` = 0.
- R11: Outputs change on the clock edge after the one that sees `instr_valid` high. After a cycle without a strobe, `wr_en`, `flag_upd` and `no_match` are 0, and `result`, `dst_idx` and `flag_val` keep their values.
- R12: While reset is asserted, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction strobe |
| instr_word | input | 16 | Instruction word |
| reg_value | input | 8 | Current value of the addressed register |
| carry_in | input | 1 | Current carry flag |
| result | output | 8 | New register byte |
| dst_idx | output | 5 | Destination register index |
| wr_en | output | 1 | Register write request |
| flag_val | output | 8 | New status bits (C0 Z1 N2 V3 S4 H5 T6 I7) |
| flag_upd | output | 8 | Per-bit update mask for `flag_val` |
| no_match | output | 1 | Strobe: word is not in the group |

## Verification
Carry-out and zero detection can both be true in the same cycle. Shifting 0x01 gives a zero result while the bit moved out is a 1. So a logical shift of 0x01 must report C=1, Z=1, V=1 and S=1 together. A rotate of 0x00 with carry in set is a second case: it yields 0x80 with C clear, N=V=1 and S=0. Both are driven as directed stimuli and compared field by field against a model built from the requirements.

// File: rtl/shr_pkg.sv
package shr_pkg;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_LSR  = 3'd1,
    OP_ROR  = 3'd2,
    OP_ASR  = 3'd3,
    OP_SWAP = 3'd4
  } shr_op_e;

  localparam int NUM_FLAGS = 8;
  localparam int FLG_C = 0;
  localparam int FLG_Z = 1;
  localparam int FLG_N = 2;
  localparam int FLG_V = 3;
  localparam int FLG_S = 4;
  localparam int FLG_H = 5;
  localparam int FLG_T = 6;
  localparam int FLG_I = 7;

  localparam logic [6:0] GROUP_PREFIX = 7'b1001010;
  localparam logic [3:0] SUB_LSR  = 4'b0110;
  localparam logic [3:0] SUB_ROR  = 4'b0111;
  localparam logic [3:0] SUB_ASR  = 4'b0101;
  localparam logic [3:0] SUB_SWAP = 4'b0010;

endpackage

// File: rtl/shr_decode.sv
module shr_decode
  import shr_pkg::*;
#(
  parameter int INSTR_W = 16,
  parameter int IDX_W   = 5
) (
  input  logic [INSTR_W-1:0] instr,
  output shr_op_e            op,
  output logic [IDX_W-1:0]   idx
);

  localparam int SUB_W  = 4;
  localparam int IDX_LO = SUB_W;
  localparam int PFX_LO = SUB_W + IDX_W;

  logic prefix_hit;

  always_comb begin
    prefix_hit = (instr[INSTR_W-1:PFX_LO] == GROUP_PREFIX);
    idx        = instr[IDX_LO +: IDX_W];
    op         = OP_NONE;
    if (prefix_hit) begin
      unique case (instr[SUB_W-1:0])
        SUB_LSR:  op = OP_LSR;
        SUB_ROR:  op = OP_ROR;
        SUB_ASR:  op = OP_ASR;
        SUB_SWAP: op = OP_SWAP;
        default:  op = OP_NONE;
      endcase
    end
  end

endmodule

// File: rtl/shr_datapath.sv
module shr_datapath
  import shr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  shr_op_e           op,
  input  logic [DATA_W-1:0] value,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout
);

  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] swapped;
  logic              fill_bit;

  genvar g;
  generate
    for (g = 0; g < HALF; g++) begin : g_swap
      assign swapped[g]        = value[g + HALF];
      assign swapped[g + HALF] = value[g];
    end
  endgenerate

  always_comb begin
    unique case (op)
      OP_ROR:  fill_bit = cin;
      OP_ASR:  fill_bit = value[DATA_W-1];
      default: fill_bit = 1'b0;
    endcase
  end

  always_comb begin
    res  = value;
    cout = 1'b0;
    unique case (op)
      OP_LSR, OP_ROR, OP_ASR: begin
        res  = {fill_bit, value[DATA_W-1:1]};
        cout = value[0];
      end
      OP_SWAP: res = swapped;
      default: res = value;
    endcase
  end

endmodule

// File: rtl/shr_flag_gen.sv
module shr_flag_gen
  import shr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  shr_op_e                op,
  input  logic [DATA_W-1:0]      res,
  input  logic                   cout,
  output logic [NUM_FLAGS-1:0]   fval,
  output logic [NUM_FLAGS-1:0]   fupd
);

  logic is_shift;
  logic n_bit;
  logic v_bit;

  always_comb begin
    is_shift = (op == OP_LSR) || (op == OP_ROR) || (op == OP_ASR);
    n_bit    = (op == OP_LSR) ? 1'b0 : res[DATA_W-1];
    v_bit    = n_bit ^ cout;
    fval     = '0;
    fupd     = '0;
    if (is_shift) begin
      fval[FLG_C] = cout;
      fval[FLG_Z] = (res == '0);
      fval[FLG_N] = n_bit;
      fval[FLG_V] = v_bit;
      fval[FLG_S] = n_bit ^ v_bit;
      fupd[FLG_C] = 1'b1;
      fupd[FLG_Z] = 1'b1;
      fupd[FLG_N] = 1'b1;
      fupd[FLG_V] = 1'b1;
      fupd[FLG_S] = 1'b1;
    end
  end

endmodule

// File: rtl/shr_swap_unit.sv
module shr_swap_unit
  import shr_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int INSTR_W = 16,
  parameter int IDX_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  input  logic [INSTR_W-1:0] instr_word,
  input  logic [DATA_W-1:0]  reg_value,
  input  logic               carry_in,
  output logic [DATA_W-1:0]  result,
  output logic [IDX_W-1:0]   dst_idx,
  output logic               wr_en,
  output logic [NUM_FLAGS-1:0] flag_val,
  output logic [NUM_FLAGS-1:0] flag_upd,
  output logic               no_match
);

  shr_op_e              dec_op;
  logic [IDX_W-1:0]     dec_idx;
  logic [DATA_W-1:0]    dp_res;
  logic                 dp_cout;
  logic [NUM_FLAGS-1:0] fg_val;
  logic [NUM_FLAGS-1:0] fg_upd;

  logic                 data_en;
  logic [DATA_W-1:0]    result_d;
  logic [IDX_W-1:0]     dst_d;
  logic [NUM_FLAGS-1:0] fval_d;
  logic                 wr_en_d;
  logic [NUM_FLAGS-1:0] fupd_d;
  logic                 nm_d;

  shr_decode #(.INSTR_W(INSTR_W), .IDX_W(IDX_W)) u_dec (
    .instr (instr_word),
    .op    (dec_op),
    .idx   (dec_idx)
  );

  shr_datapath #(.DATA_W(DATA_W)) u_dp (
    .op    (dec_op),
    .value (reg_value),
    .cin   (carry_in),
    .res   (dp_res),
    .cout  (dp_cout)
  );

  shr_flag_gen #(.DATA_W(DATA_W)) u_fg (
    .op    (dec_op),
    .res   (dp_res),
    .cout  (dp_cout),
    .fval  (fg_val),
    .fupd  (fg_upd)
  );

  // next-state
  always_comb begin
    data_en  = instr_valid;
    result_d = dp_res;
    dst_d    = dec_idx;
    fval_d   = fg_val;
    wr_en_d  = instr_valid && (dec_op != OP_NONE);
    nm_d     = instr_valid && (dec_op == OP_NONE);
    fupd_d   = instr_valid ? fg_upd : '0;
  end

  // data registers, clock-enabled by the strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result   <= '0;
      dst_idx  <= '0;
      flag_val <= '0;
    end else if (data_en) begin
      result   <= result_d;
      dst_idx  <= dst_d;
      flag_val <= fval_d;
    end
  end

  // strobe registers, refreshed every cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en    <= 1'b0;
      flag_upd <= '0;
      no_match <= 1'b0;
    end else begin
      wr_en    <= wr_en_d;
      flag_upd <= fupd_d;
      no_match <= nm_d;
    end
  end

endmodule

// File: rtl/shr_swap_unit_chk.sv
module shr_swap_unit_chk #(
  parameter int DATA_W  = 8,
  parameter int IDX_W   = 5,
  parameter int NFLG    = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              instr_valid,
  input logic [DATA_W-1:0] result,
  input logic [IDX_W-1:0]  dst_idx,
  input logic              wr_en,
  input logic [NFLG-1:0]   flag_val,
  input logic [NFLG-1:0]   flag_upd,
  input logic              no_match
);

  AST_NOMATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    no_match |-> (!wr_en && flag_upd == '0)); // R10

  AST_HTI_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    flag_upd[NFLG-1:5] == '0); // R9

  AST_MASK_IMPLIES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_upd != '0) |-> wr_en); // R5

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    flag_upd[1] |-> (flag_val[1] == (result == '0))); // R6

  AST_IDLE_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> (!wr_en && !no_match && flag_upd == '0)); // R11

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> ($stable(result) && $stable(dst_idx) && $stable(flag_val))); // R11

endmodule

bind shr_swap_unit shr_swap_unit_chk #(
  .DATA_W(DATA_W), .IDX_W(IDX_W), .NFLG(shr_pkg::NUM_FLAGS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid),
  .result(result), .dst_idx(dst_idx), .wr_en(wr_en),
  .flag_val(flag_val), .flag_upd(flag_upd), .no_match(no_match)
);

// File: tb/tb_shr_swap_unit.sv
module tb_shr_swap_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [15:0] instr_word = '0;
  logic [7:0]  reg_value = '0;
  logic        carry_in = 1'b0;
  logic [7:0]  result;
  logic [4:0]  dst_idx;
  logic        wr_en;
  logic [7:0]  flag_val;
  logic [7:0]  flag_upd;
  logic        no_match;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  shr_swap_unit dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid),
    .instr_word(instr_word), .reg_value(reg_value), .carry_in(carry_in),
    .result(result), .dst_idx(dst_idx), .wr_en(wr_en),
    .flag_val(flag_val), .flag_upd(flag_upd), .no_match(no_match)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input logic [3:0] sub, input logic [4:0] d);
    return {7'b1001010, d, sub};
  endfunction

  // Issue one word, check outputs one edge later.
  task automatic run_op(input logic [15:0] iw, input logic [7:0] v, input logic c,
                        input string tag);
    logic [7:0] er; logic ec, en, ev, ez; logic [3:0] sub; int kind;
    sub = iw[3:0];
    kind = 0;
    if (iw[15:9] == 7'b1001010) begin
      if (sub == 4'h6) kind = 1;
      else if (sub == 4'h7) kind = 2;
      else if (sub == 4'h5) kind = 3;
      else if (sub == 4'h2) kind = 4;
    end
    er = v; ec = 0;
    case (kind)
      1: begin er = v >> 1; ec = v[0]; end
      2: begin er = {c, v[7:1]}; ec = v[0]; end
      3: begin er = {v[7], v[7:1]}; ec = v[0]; end
      4: er = {v[3:0], v[7:4]};
      default: ;
    endcase
    ez = (er == 8'h00);
    en = (kind == 1) ? 1'b0 : er[7];
    ev = en ^ ec;
    @(negedge clk);
    instr_word = iw; reg_value = v; carry_in = c; instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    if (kind == 0) begin
      chk("R10", "no_match", no_match, 1);
      chk("R10", "wr_en", wr_en, 0);
      chk("R10", "flag_upd", flag_upd, 0);
    end else begin
      chk("R11", "no_match", no_match, 0);
      chk(tag, "result", result, er);
      chk("R1", "dst_idx", dst_idx, iw[8:4]);
      chk(tag, "wr_en", wr_en, 1);
      if (kind == 4) begin
        chk("R5", "flag_upd", flag_upd, 0);
      end else begin
        chk("R9", "flag_upd", flag_upd, 8'h1F);
        chk(tag, "C", flag_val[0], ec);
        chk("R6", "Z", flag_val[1], ez);
        chk((kind == 1) ? "R7" : "R8", "N", flag_val[2], en);
        chk((kind == 1) ? "R7" : "R8", "V", flag_val[3], ev);
        chk((kind == 1) ? "R7" : "R8", "S", flag_val[4], en ^ ev);
      end
    end
  endtask

  task automatic t_reset();
    chk("R12", "result", result, 0);
    chk("R12", "dst_idx", dst_idx, 0);
    chk("R12", "wr_en", wr_en, 0);
    chk("R12", "flag_val", flag_val, 0);
    chk("R12", "flag_upd", flag_upd, 0);
    chk("R12", "no_match", no_match, 0);
  endtask

  task automatic t_lsr();
    run_op(mk(4'h6, 5'd3), 8'h01, 1'b0, "R2");  // zero + carry together
    run_op(mk(4'h6, 5'd31), 8'h80, 1'b1, "R2");
    run_op(mk(4'h6, 5'd0), 8'hFF, 1'b0, "R2");
  endtask

  task automatic t_ror();
    run_op(mk(4'h7, 5'd7), 8'h00, 1'b1, "R3");
    run_op(mk(4'h7, 5'd18), 8'h01, 1'b0, "R3");
    run_op(mk(4'h7, 5'd9), 8'hA5, 1'b1, "R3");
  endtask

  task automatic t_asr();
    run_op(mk(4'h5, 5'd21), 8'h81, 1'b0, "R4");
    run_op(mk(4'h5, 5'd1), 8'h02, 1'b1, "R4");
    run_op(mk(4'h5, 5'd10), 8'h01, 1'b0, "R4");
  endtask

  task automatic t_swap();
    run_op(mk(4'h2, 5'd5), 8'hA5, 1'b1, "R5");
    run_op(mk(4'h2, 5'd30), 8'h0F, 1'b0, "R5");
  endtask

  task automatic t_nomatch();
    run_op(mk(4'h3, 5'd4), 8'h55, 1'b0, "R10");
    run_op({7'b1001011, 5'd4, 4'h6}, 8'h55, 1'b0, "R10");
    run_op(16'h0000, 8'h00, 1'b0, "R10");
  endtask

  task automatic t_hold();
    logic [7:0] r; logic [7:0] f; logic [4:0] d;
    run_op(mk(4'h7, 5'd12), 8'h3C, 1'b1, "R3");
    r = result; f = flag_val; d = dst_idx;
    instr_word = mk(4'h6, 5'd2); reg_value = 8'hFF;  // valid stays low
    @(negedge clk);
    chk("R11", "wr_en idle", wr_en, 0);
    chk("R11", "flag_upd idle", flag_upd, 0);
    chk("R11", "no_match idle", no_match, 0);
    chk("R11", "result held", result, r);
    chk("R11", "flag_val held", flag_val, f);
    chk("R11", "dst_idx held", dst_idx, d);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lsr();
    t_ror();
    t_asr();
    t_swap();
    t_nomatch();
    t_hold();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog act=%0h exp=%0h", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule